// File: doc/BRIEF.md
# I2S Transmit Serializer with Bit Clock Divider

This block is the transmit end of an audio serial port and acts as clock master. It takes 32-bit sample words from a show-ahead transmit FIFO and sends them as a standard I2S stream. It divides the master clock down to a bit clock, generates word select, and shifts out the low bits of each sample MSB first. Every frame carries two channels, left and then right, and each channel takes one FIFO word.

Raising the enable starts the bit clock. The first frame after each start carries zeros in both channels and pops nothing. Queued data follows from the second frame on. If the FIFO runs dry, the block sends zeros and keeps the clocks running; it does not stall. Lowering the enable lets the current frame finish. The block then stops at the frame boundary with every output low. The divide ratio and the resolution are captured when the block starts, and they stay fixed until it goes idle again.

Top module: `i2s_tx_serializer`

## Requirements
- R1: Each bit clock phase, high and low, lasts `ratio_i + 2` master clock cycles, so the period is 2·(ratio_i+2) cycles. `ratio_i` is an unsigned 8-bit value.
- R2: After reset, and whenever the block is idle, `bclk_o`, `ws_o`, `sd_o` and `fifo_pop_o` are all low.
- R3: The first frame after each start sends zero in both channels, with the left channel first, and pops no word.
- R4: `ws_o` is 0 for the left channel and 1 for the right channel. Each channel lasts `res_i` bit clocks. `ws_o` changes one bit clock before the MSB of the channel it announces.
- R5: Each channel sends bits `res_i-1` down to 0 of its word, MSB first. `res_i` may be 2 to 32. `ws_o` and `sd_o` change only together with a falling `bclk_o`.
- R6: In a data frame, one word is popped at the start of the left half and one at the start of the right half. A pop lasts one master clock cycle, comes while `bclk_o` is still high just before it falls, and never happens while `fifo_empty_i` is high.
- R7: If the FIFO is empty when a frame starts, that whole frame is zeros and nothing is popped during it.
- R8: If the left word was popped but the FIFO is empty when the right half starts, the right channel sends zeros and nothing is popped.
- R9: When `enable_i` goes low, the current frame completes. The clocks then stop low at the frame boundary. Enabling again sends a new zero frame first.
- R10: `ratio_i` and `res_i` are sampled when the block starts. Changes to them while the block runs have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Transmit enable |
| ratio_i | input | 8 | Bit clock divide ratio |
| res_i | input | 6 | Bits sent per channel (2 to 32) |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_data_i | input | 32 | Head word of the FIFO, valid while not empty |
| fifo_pop_o | output | 1 | Consume the head word |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume that the FIFO is show-ahead. They also assume that `fifo_empty_i` and `fifo_data_i` change only after a pop or when the FIFO is refilled, and that `res_i` is between 2 and 32 whenever the block starts. The bench keeps to these assumptions. Its FIFO model advances the read pointer only on a sampled pop, and the FIFO is loaded only while the block is idle. The bench always starts the block with a legal resolution. Values of `ratio_i` and `res_i` that do not match the captured ones are applied only while the block is running, which is where R10 says they must be ignored.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned PKG_DATA_W  = 32;
  localparam int unsigned PKG_RATIO_W = 8;
  localparam int unsigned PKG_RES_W   = 6;
endpackage

// File: rtl/i2s_tx_bclk_div.sv
module i2s_tx_bclk_div #(
  parameter int unsigned RATIO_W = 8,
  localparam int unsigned CNT_W  = RATIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               bclk_o,
  output logic               fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] phase_len;
  logic             wrap;
  logic             bclk_q;

  assign phase_len = {1'b0, ratio_i} + CNT_W'(2);
  assign wrap      = (cnt_q == phase_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = run_i & bclk_q & wrap;
endmodule

// File: rtl/i2s_tx_slot_seq.sv
module i2s_tx_slot_seq #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned RES_W   = 6,
  parameter int unsigned POS_W   = 5,
  localparam int unsigned SLOT_W = RES_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               fall_i,
  input  logic               fifo_empty_i,
  output logic               run_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [RES_W-1:0]   res_o,
  output logic               upd_o,
  output logic               stop_o,
  output logic               load_o,
  output logic               take_o,
  output logic [POS_W-1:0]   bitpos_o,
  output logic               ws_o
);
  logic               run_q, zero_q, ws_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RES_W-1:0]   res_q, res_n;
  logic [SLOT_W-1:0]  slot_q, slot_n, res_ext, frame_len, j, pos_full, nxt1;
  logic               start, adv, last, stop, upd, half, load, take, ws_n;

  assign start     = !run_q & enable_i;
  assign adv       = run_q & fall_i;
  assign res_n     = start ? res_i : res_q;
  assign res_ext   = {1'b0, res_n};
  assign frame_len = res_ext << 1;
  assign last      = (slot_q == frame_len - 1'b1);
  assign stop      = adv & last & !enable_i;
  assign upd       = start | (adv & !stop);
  assign slot_n    = (start || last) ? '0 : slot_q + 1'b1;
  assign half      = (slot_n >= res_ext);
  assign j         = half ? slot_n - res_ext : slot_n;
  assign pos_full  = res_ext - 1'b1 - j;
  assign load      = upd & (j == '0);
  // word select leads the data by one slot
  assign nxt1      = slot_n + 1'b1;
  assign ws_n      = (nxt1 == frame_len) ? 1'b0 : (nxt1 >= res_ext);

  always_comb begin
    take = 1'b0;
    if (load && !start) begin
      if (slot_n == '0) take = !fifo_empty_i;
      else              take = !zero_q & !fifo_empty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      zero_q  <= 1'b1;
      ws_q    <= 1'b0;
      slot_q  <= '0;
      ratio_q <= '0;
      res_q   <= RES_W'(2);
    end else begin
      if (start) begin
        run_q   <= 1'b1;
        ratio_q <= ratio_i;
        res_q   <= res_i;
        zero_q  <= 1'b1;
      end else if (upd && slot_n == '0) begin
        zero_q  <= fifo_empty_i;
      end
      if (stop) begin
        run_q  <= 1'b0;
        ws_q   <= 1'b0;
        slot_q <= '0;
      end else if (upd) begin
        ws_q   <= ws_n;
        slot_q <= slot_n;
      end
    end
  end

  assign run_o    = run_q;
  assign ratio_o  = ratio_q;
  assign res_o    = res_q;
  assign upd_o    = upd;
  assign stop_o   = stop;
  assign load_o   = load;
  assign take_o   = take;
  assign bitpos_o = pos_full[POS_W-1:0];
  assign ws_o     = ws_q;
endmodule

// File: rtl/i2s_tx_sd_out.sv
module i2s_tx_sd_out #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              stop_i,
  input  logic              load_i,
  input  logic              take_i,
  input  logic [POS_W-1:0]  bitpos_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sd_o
);
  logic [DATA_W-1:0] word_q, word_n;
  logic              sd_q;

  assign word_n = take_i ? data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (stop_i)      sd_q <= 1'b0;
      else if (upd_i)  sd_q <= load_i ? word_n[bitpos_i] : word_q[bitpos_i];
      if (load_i)      word_q <= word_n;
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = PKG_DATA_W,
  parameter int unsigned RATIO_W = PKG_RATIO_W,
  parameter int unsigned RES_W   = PKG_RES_W,
  localparam int unsigned POS_W  = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               fifo_empty_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  output logic               fifo_pop_o,
  output logic               bclk_o,
  output logic               ws_o,
  output logic               sd_o
);
  logic               run, fall, upd, stop, load, take;
  logic [RATIO_W-1:0] ratio_lat;
  logic [RES_W-1:0]   res_lat;
  logic [POS_W-1:0]   bitpos;

  i2s_tx_bclk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ratio_i (ratio_lat),
    .bclk_o  (bclk_o),
    .fall_o  (fall)
  );

  i2s_tx_slot_seq #(.RATIO_W(RATIO_W), .RES_W(RES_W), .POS_W(POS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .ratio_i      (ratio_i),
    .res_i        (res_i),
    .fall_i       (fall),
    .fifo_empty_i (fifo_empty_i),
    .run_o        (run),
    .ratio_o      (ratio_lat),
    .res_o        (res_lat),
    .upd_o        (upd),
    .stop_o       (stop),
    .load_o       (load),
    .take_o       (take),
    .bitpos_o     (bitpos),
    .ws_o         (ws_o)
  );

  i2s_tx_sd_out #(.DATA_W(DATA_W), .POS_W(POS_W)) u_sd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .stop_i   (stop),
    .load_i   (load),
    .take_i   (take),
    .bitpos_i (bitpos),
    .data_i   (fifo_data_i),
    .sd_o     (sd_o)
  );

  assign fifo_pop_o = take;
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned RES_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fifo_empty_i,
  input logic               fifo_pop_o,
  input logic               bclk_o,
  input logic               ws_o,
  input logic               sd_o,
  input logic               run_i,
  input logic [RATIO_W-1:0] ratio_lat_i,
  input logic [RES_W-1:0]   res_lat_i
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!bclk_o && !ws_o && !sd_o && !fifo_pop_o));

  p_start_left_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (!ws_o && !sd_o && !bclk_o));

  p_change_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(bclk_o) |-> ($stable(ws_o) && $stable(sd_o)));

  p_pop_needs_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  p_pop_before_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> bclk_o);

  p_pop_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(ratio_lat_i) && $stable(res_lat_i)));
endmodule

bind i2s_tx_serializer i2s_tx_checker #(.RATIO_W(RATIO_W), .RES_W(RES_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_empty_i (fifo_empty_i),
  .fifo_pop_o   (fifo_pop_o),
  .bclk_o       (bclk_o),
  .ws_o         (ws_o),
  .sd_o         (sd_o),
  .run_i        (run),
  .ratio_lat_i  (ratio_lat),
  .res_lat_i    (res_lat)
);

// File: tb/tb_i2s_tx_serializer.sv
module tb_i2s_tx_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int CAP_N      = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [7:0]  ratio_i = '0;
  logic [5:0]  res_i = 6'd32;
  logic        fifo_empty_i;
  logic [31:0] fifo_data_i;
  logic        fifo_pop_o, bclk_o, ws_o, sd_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [64];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int cyc = 0;

  logic cap_ws [CAP_N];
  logic cap_sd [CAP_N];
  int   rise_t [CAP_N];
  int   cap_n = 0;
  logic bclk_prev = 1'b0;
  int   hi_run = 0;
  int   last_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_serializer dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .ratio_i      (ratio_i),
    .res_i        (res_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_pop_o   (fifo_pop_o),
    .bclk_o       (bclk_o),
    .ws_o         (ws_o),
    .sd_o         (sd_o)
  );

  // show-ahead FIFO model
  assign fifo_empty_i = (rd_ptr == wr_ptr);
  assign fifo_data_i  = mem[rd_ptr % 64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_pop_o) rd_ptr <= rd_ptr + 1;
  end

  // receiver: sample on each rising bit clock
  always @(negedge clk) begin
    bclk_prev <= bclk_o;
    if (bclk_o && !bclk_prev && cap_n < CAP_N) begin
      cap_ws[cap_n] <= ws_o;
      cap_sd[cap_n] <= sd_o;
      rise_t[cap_n] <= cyc;
      cap_n <= cap_n + 1;
    end
    if (bclk_o) hi_run <= bclk_prev ? hi_run + 1 : 1;
    if (!bclk_o && bclk_prev) last_hi <= hi_run;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'h9E3779B9 * (k + 7) ^ 32'h5A5A0F0F;
  endfunction

  task automatic check_idle(input string tag);
    int bad = 0;
    int base_rd = rd_ptr;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o || ws_o || sd_o || fifo_pop_o) bad++;
    end
    chk({tag, " R2 idle outputs low"}, bad, 0);
    chk({tag, " R2 no pop while idle"}, rd_ptr - base_rd, 0);
  endtask

  task automatic run_stream(input int ratio, input int res, input int nwords,
                            input int nframes, input bit poke, input string tag);
    int h, base_cap, base_rd, start_w, nslots, avail, idx, pops, bad;
    logic [31:0] el [8];
    logic [31:0] er [8];
    logic [31:0] mask, act;
    h = ratio + 2;
    nslots = nframes * 2 * res;
    mask = (res == 32) ? 32'hFFFF_FFFF : ((32'h1 << res) - 1);
    start_w = wr_ptr;
    for (int i = 0; i < nwords; i++) mem[(start_w + i) % 64] = pat(start_w + i);
    wr_ptr = wr_ptr + nwords;
    // expected frames: zero frame first, then FIFO words, zeros on underrun
    avail = nwords; idx = 0; pops = 0;
    for (int f = 0; f < nframes; f++) begin
      el[f] = '0; er[f] = '0;
      if (f > 0 && avail > 0) begin
        el[f] = pat(start_w + idx); idx++; avail--; pops++;
        if (avail > 0) begin er[f] = pat(start_w + idx); idx++; avail--; pops++; end
      end
    end
    @(negedge clk);
    ratio_i = 8'(ratio);
    res_i = 6'(res);
    base_cap = cap_n;
    base_rd = rd_ptr;
    enable_i = 1'b1;
    if (poke) begin
      while (cap_n < base_cap + 3) @(negedge clk);
      ratio_i = 8'(ratio + 3);
      res_i = 6'(res / 2);
    end
    while (cap_n < base_cap + nslots) @(negedge clk);
    enable_i = 1'b0;
    repeat (4 * res * h + 20) @(negedge clk);
    chk({tag, " R9 stops at frame boundary"}, cap_n - base_cap, nslots);
    for (int f = 0; f < nframes; f++) begin
      for (int c = 0; c < 2; c++) begin
        act = '0;
        for (int b = 0; b < res; b++)
          act = (act << 1) | 32'(cap_sd[base_cap + f*2*res + c*res + b]);
        if (f == 0) chk({tag, " R3 zero frame"}, act, 32'h0);
        else if (c == 0) chk({tag, " R5 R6 left word"}, act, el[f] & mask);
        else chk({tag, " R5 R8 right word"}, act, er[f] & mask);
      end
      bad = 0;
      for (int s = 0; s < 2*res; s++)
        if (cap_ws[base_cap + f*2*res + s] !== ((((s + 1) % (2*res)) >= res) ? 1'b1 : 1'b0)) bad++;
      chk({tag, " R4 word select slots"}, bad, 0);
    end
    bad = 0;
    for (int i = 1; i < nslots; i++)
      if (rise_t[base_cap + i] - rise_t[base_cap + i - 1] != 2*h) bad++;
    chk({tag, " R1 bit clock period"}, rise_t[base_cap + 1] - rise_t[base_cap], 2*h);
    chk({tag, " R1 R10 all periods"}, bad, 0);
    chk({tag, " R1 high phase"}, last_hi, h);
    chk({tag, " R6 R7 pop count"}, rd_ptr - base_rd, pops);
    chk({tag, " R9 bclk low after stop"}, bclk_o, 0);
    ratio_i = 8'(ratio);
    res_i = 6'(res);
  endtask

  task automatic stop_mid();
    int base_cap, base_rd;
    @(negedge clk);
    ratio_i = 8'd1;
    res_i = 6'd8;
    base_cap = cap_n;
    base_rd = rd_ptr;
    enable_i = 1'b1;
    while (cap_n < base_cap + 9) @(negedge clk);
    enable_i = 1'b0;
    repeat (2 * 8 * 2 * 3 + 20) @(negedge clk);
    chk("stop_mid R9 frame completes", cap_n - base_cap, 16);
    chk("stop_mid R7 empty no pop", rd_ptr - base_rd, 0);
    check_idle("stop_mid");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R2 bclk", bclk_o, 0);
    chk("reset R2 ws", ws_o, 0);
    chk("reset R2 sd", sd_o, 0);
    chk("reset R2 pop", fifo_pop_o, 0);
    rst_ni = 1'b1;
    check_idle("after_reset");
    run_stream(0, 32, 6, 4, 1'b0, "full32");      // R3 R5 R6
    run_stream(2, 16, 3, 4, 1'b0, "underrun16");  // R7 R8
    run_stream(5, 8, 4, 3, 1'b1, "cfg_poke");     // R10
    stop_mid();                                   // R9
    run_stream(0, 24, 2, 2, 1'b0, "res24");       // R5 truncation, R9 re-enable zero frame
    run_stream(255, 2, 2, 3, 1'b0, "slow2");      // R1 largest ratio, smallest res
    check_idle("end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule